// File: doc/BRIEF.md
# Maximal-Length Shift-Feedback Counter

This block is a free-running pseudo-random counter built from a shift register. On every enabled rising clock edge each register bit moves one place toward the most significant end. The new bit 0 is the XOR of a small set of register bits. That set comes from a fixed table indexed by the `WIDTH` parameter, which may be 2 to 8. Each table entry is a primitive feedback set, so the counter steps through every nonzero `WIDTH`-bit value once before the pattern repeats.

Reset loads a nonzero seed, because a cleared register would map onto itself forever. A recovery path also watches for the cleared state and replaces it with the seed. The register value is presented directly as the parallel output. It is typically used for test-pattern generation, scrambling or cheap long-period timers.

Top module: `lfsr_counter`

## Requirements
- R1: While `rst_n` is low, `q` equals the seed value 1 (bit 0 set, all other bits clear), without waiting for a clock edge.
- R2: On a rising edge with `en` high and a nonzero state, `q[i]` takes the previous `q[i-1]` for every i from 1 to WIDTH-1.
- R3: On such an edge, the new `q[0]` is the XOR of these previous bits, listed by width: 2 → q0,q1; 3 → q1,q2; 4 → q2,q3; 5 → q2,q4; 6 → q4,q5; 7 → q3,q6; 8 → q3,q4,q5,q7.
- R4: With WIDTH=4, starting from the seed, `q` (written as a hex value) runs through 1,2,4,9,3,6,D,A,5,B,7,F,E,C,8 and then returns to 1.
- R5: For every width from 2 to 8, the counter first returns to the seed after exactly 2^WIDTH−1 enabled edges, and `q` is never zero along the way.
- R6: On a rising edge with `en` low and a nonzero state, `q` keeps its value.
- R7: If the register holds all zeros at a rising edge, `q` becomes the seed after that edge. This happens whatever the level of `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset, loads the seed |
| en | input | 1 | Synchronous advance enable |
| q | output | WIDTH | Current register state, bit i is stage i |

## Verification
The all-zero state cannot be reached from the ports, because reset loads the seed and every feedback step from a nonzero value gives a nonzero value. To exercise the recovery path, the bench holds reset low and forces the state register to zero. It then releases the force and raises reset before the next clock edge. The following edge must restore the seed, and this is checked at `q`. The period claims are covered by separate instances for each width from 2 to 8. Each instance is compared step by step against an arithmetic model until it returns to the seed.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int unsigned LFSR_MAX_W = 8;

  // Feedback selection in stage order: bit i set means stage i feeds the XOR.
  function automatic logic [LFSR_MAX_W-1:0] lfsr_taps(input int unsigned w);
    logic [LFSR_MAX_W-1:0] m;
    case (w)
      2:       m = 8'b0000_0011;
      3:       m = 8'b0000_0110;
      4:       m = 8'b0000_1100;
      5:       m = 8'b0001_0100;
      6:       m = 8'b0011_0000;
      7:       m = 8'b0100_1000;
      8:       m = 8'b1011_1000;
      default: m = 8'b0000_0000;
    endcase
    return m;
  endfunction

  // Value loaded at reset and on lock-up recovery.
  function automatic logic [LFSR_MAX_W-1:0] lfsr_seed();
    return {{(LFSR_MAX_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
  import lfsr_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] state,
  output logic         fb,
  output logic         all_zero
);
  localparam logic [LFSR_MAX_W-1:0] TAPS = lfsr_taps(W);

  logic [W:0] chain;
  assign chain[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_tap
      if (TAPS[i]) begin : g_use
        assign chain[i+1] = chain[i] ^ state[i];
      end else begin : g_skip
        assign chain[i+1] = chain[i];
      end
    end
  endgenerate

  assign fb       = chain[W];
  assign all_zero = (state == '0);
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
  import lfsr_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fb,
  input  logic         all_zero,
  output logic [W-1:0] state_q
);
  localparam logic [LFSR_MAX_W-1:0] SEED_FULL = lfsr_seed();
  localparam logic [W-1:0]          SEED      = SEED_FULL[W-1:0];

  logic         recover;
  logic         advance;
  logic [W-1:0] shifted;

  assign recover = all_zero;
  assign advance = en && !all_zero;
  assign shifted = {state_q[W-2:0], fb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (recover) state_q <= SEED;
    else if (advance) state_q <= shifted;
  end

  assert_reset_seed_R1: assert property (@(posedge clk)
    !rst_n |-> state_q == SEED);

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q != '0) |=> state_q[W-1:1] == $past(state_q[W-2:0]));

  assert_feedback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q != '0) |=> state_q[0] == $past(fb));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && state_q != '0) |=> $stable(state_q));

  assert_recover_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0) |=> state_q == SEED);
endmodule

// File: rtl/lfsr_counter.sv
module lfsr_counter
  import lfsr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] state;
  logic             fb;
  logic             all_zero;

  lfsr_feedback #(.W(WIDTH)) u_fb (
    .state    (state),
    .fb       (fb),
    .all_zero (all_zero)
  );

  lfsr_state_reg #(.W(WIDTH)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .fb       (fb),
    .all_zero (all_zero),
    .state_q  (state)
  );

  assign q = state;
endmodule

// File: tb/tb_lfsr_counter.sv
module tb_lfsr_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       en = 1'b0;
  logic [3:0] q;
  logic       sw_rst_n = 1'b1;
  int         checks = 0;
  int         fails = 0;
  logic [8:2] sw_done = '0;

  always #5 clk = ~clk;

  lfsr_counter #(.WIDTH(4)) dut (.clk(clk), .rst_n(rst_n), .en(en), .q(q));

  // Arithmetic model: taps given as distances from the output end.
  function automatic logic [7:0] ref_next(input int w, input logic [7:0] s);
    logic f;
    case (w)
      5:       f = s[w-3] ^ s[w-1];
      7:       f = s[w-4] ^ s[w-1];
      8:       f = s[w-5] ^ s[w-4] ^ s[w-3] ^ s[w-1];
      default: f = s[w-2] ^ s[w-1];
    endcase
    return ((s << 1) | {7'd0, f}) & ((8'd1 << w) - 8'd1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  genvar gw;
  generate
    for (gw = 2; gw <= 8; gw++) begin : g_sw
      logic [gw-1:0] sq;
      lfsr_counter #(.WIDTH(gw)) u_sw (.clk(clk), .rst_n(sw_rst_n), .en(1'b1), .q(sq));
      initial begin
        logic [7:0] e;
        int steps;
        int bad;
        int zero_seen;
        wait (sw_rst_n === 1'b1);
        @(negedge clk);
        e = 8'd1; steps = 0; bad = 0; zero_seen = 0;
        while (steps < 300) begin
          @(negedge clk);
          e = ref_next(gw, e);
          steps++;
          if ({{(8-gw){1'b0}}, sq} != e) bad++;
          if (sq == '0) zero_seen++;
          if (sq == 1) break;
        end
        chk(bad == 0, "R3 feedback vs model", bad, 0);
        chk(zero_seen == 0, "R5 never zero", zero_seen, 0);
        chk(steps == (1 << gw) - 1, "R5 period", steps, (1 << gw) - 1);
        sw_done[gw] = 1'b1;
      end
    end
  endgenerate

  initial begin
    logic [3:0] seq [15];
    logic [3:0] prev;
    seq = '{4'h1, 4'h2, 4'h4, 4'h9, 4'h3, 4'h6, 4'hD, 4'hA,
            4'h5, 4'hB, 4'h7, 4'hF, 4'hE, 4'hC, 4'h8};
    rst_n = 1'b0;
    sw_rst_n = 1'b0;
    #3;
    chk(q == 4'h1, "R1 reset seed", q, 1);
    @(negedge clk);
    chk(q == 4'h1, "R1 seed held in reset", q, 1);
    rst_n = 1'b1; sw_rst_n = 1'b1; en = 1'b1;
    chk(q == 4'h1, "R4 start", q, 1);
    for (int k = 1; k <= 16; k++) begin
      prev = q;
      @(negedge clk);
      chk(q == seq[k % 15], "R4 sequence", q, seq[k % 15]);
      chk(q[3:1] == prev[2:0], "R2 shift", q[3:1], prev[2:0]);
    end
    // R6: hold with enable low
    prev = q;
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(q == prev, "R6 hold", q, prev);
    end
    en = 1'b1;
    @(negedge clk);
    chk(q == ref_next(4, {4'd0, prev}), "R3 resume", q, ref_next(4, {4'd0, prev}));
    // R1: asynchronous reset mid-cycle
    #2 rst_n = 1'b0;
    #1 chk(q == 4'h1, "R1 async reset", q, 1);
    @(negedge clk);
    chk(q == 4'h1, "R1 held across edge", q, 1);
    // R7: drive the unreachable all-zero state, then leave reset
    force dut.u_reg.state_q = 4'h0;
    #1 release dut.u_reg.state_q;
    rst_n = 1'b1;
    #1 chk(q == 4'h0, "R7 zero state present", q, 0);
    @(negedge clk);
    chk(q == 4'h1, "R7 recovery to seed", q, 1);
    @(negedge clk);
    chk(q == 4'h2, "R7 resumes counting", q, 2);
    wait (sw_done == 7'h7F);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule